// File: doc/BRIEF.md
# Queue Enable Controller with Context Fetch

This block runs the enable and disable handshake for a set of receive and transmit descriptor queues. Software writes a request bit per queue. A request on an idle queue moves the queue into an enabling state, and the block issues one read of that queue's context record from a table in host memory. The queue reports enabled only after that read completes. Clearing the request bit drops the queue at once, with no memory traffic.

All queues share one registered memory-request port. Pending fetches are granted round-robin. Each request carries a tag that names the direction and the queue, and the completion returns the same tag. Tail-register writes become doorbell pulses to the queue engine only while the target queue is enabled. When a fetch completes on a queue that is still requested, the block sends a doorbell so that the engine picks up any tail value written during the fetch.

Top module: `qctx_enable_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, every status bit is 0, every doorbell bit is 0 and `mem_req_valid` is 0.
- R2: A request write of 1 on a queue that is neither enabling nor enabled produces exactly one read. The read has `mem_req_write`=0 and tag {rx, idx}, where bit IDXW is 1 for receive. Its address is base×512 + 32×idx for receive or base×512 + 128×idx for transmit, and its length is 32 or 128 bytes to match.
- R3: A request write of 1 on a queue that is enabling or enabled issues no further read.
- R4: A completion whose tag names an enabling queue with the request bit still set raises that queue's status bit at the next clock edge. It also pulses that queue's doorbell at the same edge.
- R5: A request write of 0 on an enabled queue clears its status bit at the next clock edge and issues no read.
- R6: A tail write on a queue whose status is 0 gives no doorbell. A tail write on an enabled queue pulses that queue's doorbell bit for one cycle, one edge later.
- R7: If the request bit is cleared while a fetch is outstanding, the completion leaves the status at 0 and gives no doorbell.
- R8: A request held with `mem_req_ready` low keeps its address, length and tag unchanged. Pending fetches are granted in rotating order, starting after the last one granted.
- R9: A completion and a tail write in the same cycle each produce their doorbell. When both target the same queue, the result is a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ena_wr | input | 1 | Request-bit write strobe |
| ena_rx | input | 1 | Write targets a receive queue (1) or a transmit queue (0) |
| ena_idx | input | IDXW | Queue index of the request write |
| ena_req | input | 1 | Value written to the request bit |
| tail_wr | input | 1 | Tail-register write strobe |
| tail_rx | input | 1 | Tail write targets a receive queue |
| tail_idx | input | IDXW | Queue index of the tail write |
| rx_ctx_base | input | BASEW | Receive context table base, in 512-byte units |
| tx_ctx_base | input | BASEW | Transmit context table base, in 512-byte units |
| mem_req_valid | output | 1 | Context read request valid |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_addr | output | AW | Byte address of the context record |
| mem_req_len | output | 8 | Read length in bytes |
| mem_req_write | output | 1 | Request kind, always 0 (read) |
| mem_req_tag | output | IDXW+1 | {rx, idx} of the requesting queue |
| mem_cpl_valid | input | 1 | Read completion strobe |
| mem_cpl_tag | input | IDXW+1 | Tag of the completed read |
| q_stat_rx | output | NQ | Enabled status, receive queues |
| q_stat_tx | output | NQ | Enabled status, transmit queues |
| db_rx | output | NQ | Doorbell pulses, receive queues |
| db_tx | output | NQ | Doorbell pulses, transmit queues |

## Verification
Two events can land on one queue in the same cycle: a fetch completion and a tail write. Both can pulse the doorbell. The bench drives them in a single cycle, first on two different queues and then on the same queue. It counts the doorbell pulses per queue, and expects one for each queue in the first case and a single pulse in the second. Completion against a request write of 0 in the same cycle also comes up in the random phase. There a reference model in the bench predicts status bits, doorbell counts and fetch counts for every queue.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int BASE_SHIFT   = 9;
  localparam int RX_CTX_LOG2  = 5;
  localparam int TX_CTX_LOG2  = 7;
  localparam int LEN_W        = 8;
  localparam logic [LEN_W-1:0] RX_CTX_LEN = LEN_W'(1 << RX_CTX_LOG2);
  localparam logic [LEN_W-1:0] TX_CTX_LEN = LEN_W'(1 << TX_CTX_LOG2);
endpackage

// File: rtl/qec_rr_arb.sv
module qec_rr_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last_q) + off) % N;
      if (!gnt_vld && req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(N - 1);
    else if (adv && gnt_vld) last_q <= gnt_idx;
  end
endmodule

// File: rtl/qec_slot.sv
module qec_slot (
  input  logic clk,
  input  logic rst,
  input  logic ena_hit,
  input  logic ena_val,
  input  logic tail_hit,
  input  logic cpl_hit,
  input  logic grant,
  output logic need,
  output logic enabled,
  output logic db
);
  logic req_q, busy_q, en_q, need_q, db_q;
  logic req_n, start;

  assign req_n = ena_hit ? ena_val : req_q;
  assign start = ena_hit && ena_val && !busy_q && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      need_q <= 1'b0;
      db_q   <= 1'b0;
    end else begin
      req_q <= req_n;
      db_q  <= (tail_hit && en_q) || (cpl_hit && busy_q && req_n);
      if (start) begin
        busy_q <= 1'b1;
        need_q <= 1'b1;
      end else if (grant) begin
        need_q <= 1'b0;
      end
      if (cpl_hit && busy_q) begin
        busy_q <= 1'b0;
        en_q   <= req_n;
      end else if (ena_hit && !ena_val) begin
        en_q <= 1'b0;
      end
    end
  end

  assign need    = need_q;
  assign enabled = en_q;
  assign db      = db_q;
endmodule

// File: rtl/qctx_enable_ctrl.sv
module qctx_enable_ctrl #(
  parameter int NQ    = 4,
  parameter int AW    = 64,
  parameter int BASEW = 32,
  localparam int IDXW = $clog2(NQ),
  localparam int NS   = 2 * NQ,
  localparam int TW   = IDXW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ena_wr,
  input  logic                     ena_rx,
  input  logic [IDXW-1:0]          ena_idx,
  input  logic                     ena_req,
  input  logic                     tail_wr,
  input  logic                     tail_rx,
  input  logic [IDXW-1:0]          tail_idx,
  input  logic [BASEW-1:0]         rx_ctx_base,
  input  logic [BASEW-1:0]         tx_ctx_base,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  output logic [qec_pkg::LEN_W-1:0] mem_req_len,
  output logic                     mem_req_write,
  output logic [TW-1:0]            mem_req_tag,
  input  logic                     mem_cpl_valid,
  input  logic [TW-1:0]            mem_cpl_tag,
  output logic [NQ-1:0]            q_stat_rx,
  output logic [NQ-1:0]            q_stat_tx,
  output logic [NQ-1:0]            db_rx,
  output logic [NQ-1:0]            db_tx
);
  import qec_pkg::*;

  logic [TW-1:0] ena_k, tail_k;
  logic [NS-1:0] need_v, en_v, db_v;
  logic          gnt_vld, adv;
  logic [TW-1:0] gnt_idx;

  assign ena_k  = {ena_rx, ena_idx};
  assign tail_k = {tail_rx, tail_idx};
  assign adv    = gnt_vld && (!mem_req_valid || mem_req_ready);

  for (genvar k = 0; k < NS; k++) begin : g_slot
    qec_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .ena_hit  (ena_wr && (ena_k == TW'(k))),
      .ena_val  (ena_req),
      .tail_hit (tail_wr && (tail_k == TW'(k))),
      .cpl_hit  (mem_cpl_valid && (mem_cpl_tag == TW'(k))),
      .grant    (adv && (gnt_idx == TW'(k))),
      .need     (need_v[k]),
      .enabled  (en_v[k]),
      .db       (db_v[k])
    );
  end

  qec_rr_arb #(.N(NS)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (need_v),
    .adv     (adv),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  logic              g_rx;
  logic [IDXW-1:0]   g_qi;
  logic [AW-1:0]     addr_n;

  assign g_rx = gnt_idx[IDXW];
  assign g_qi = gnt_idx[IDXW-1:0];

  always_comb begin
    addr_n = AW'(g_rx ? rx_ctx_base : tx_ctx_base) << BASE_SHIFT;
    addr_n = addr_n + (g_rx ? (AW'(g_qi) << RX_CTX_LOG2) : (AW'(g_qi) << TX_CTX_LOG2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_len   <= '0;
      mem_req_tag   <= '0;
    end else if (!mem_req_valid || mem_req_ready) begin
      mem_req_valid <= gnt_vld;
      if (gnt_vld) begin
        mem_req_addr <= addr_n;
        mem_req_len  <= g_rx ? RX_CTX_LEN : TX_CTX_LEN;
        mem_req_tag  <= gnt_idx;
      end
    end
  end

  assign mem_req_write = 1'b0;
  assign q_stat_tx = en_v[NQ-1:0];
  assign q_stat_rx = en_v[NS-1:NQ];
  assign db_tx     = db_v[NQ-1:0];
  assign db_rx     = db_v[NS-1:NQ];
endmodule

// File: rtl/qctx_enable_ctrl_chk.sv
module qctx_enable_ctrl_chk #(
  parameter int NQ = 4,
  parameter int AW = 64,
  localparam int IDXW = $clog2(NQ),
  localparam int NS   = 2 * NQ,
  localparam int TW   = IDXW + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            ena_wr,
  input logic            ena_rx,
  input logic [IDXW-1:0] ena_idx,
  input logic            ena_req,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input logic [7:0]      mem_req_len,
  input logic [TW-1:0]   mem_req_tag,
  input logic            mem_cpl_valid,
  input logic [TW-1:0]   mem_cpl_tag,
  input logic [NQ-1:0]   q_stat_rx,
  input logic [NQ-1:0]   q_stat_tx,
  input logic [NQ-1:0]   db_rx,
  input logic [NQ-1:0]   db_tx
);
  logic [NS-1:0] stat, db;
  assign stat = {q_stat_rx, q_stat_tx};
  assign db   = {db_rx, db_tx};

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mem_req_valid && stat == '0 && db == '0)); // R1

  AST_LEN_BY_DIR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_len == (mem_req_tag[IDXW] ? 8'd32 : 8'd128))); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag) && $stable(mem_req_len))); // R8

  for (genvar k = 0; k < NS; k++) begin : g_q
    AST_STAT_AFTER_CPL: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[k]) |-> $past(mem_cpl_valid && mem_cpl_tag == TW'(k))); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (ena_wr && !ena_req && {ena_rx, ena_idx} == TW'(k)) |=> !stat[k]); // R5

    AST_DB_GATED: assert property (@(posedge clk) disable iff (rst)
      db[k] |-> $past(stat[k] || (mem_cpl_valid && mem_cpl_tag == TW'(k)))); // R6
  end
endmodule

bind qctx_enable_ctrl qctx_enable_ctrl_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ena_wr(ena_wr), .ena_rx(ena_rx), .ena_idx(ena_idx),
  .ena_req(ena_req), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_req_tag(mem_req_tag),
  .mem_cpl_valid(mem_cpl_valid), .mem_cpl_tag(mem_cpl_tag), .q_stat_rx(q_stat_rx),
  .q_stat_tx(q_stat_tx), .db_rx(db_rx), .db_tx(db_tx)
);

// File: tb/qctx_enable_ctrl_test.sv
`timescale 1ns/1ps
module qctx_enable_ctrl_test;
  localparam int NQ = 4;
  localparam int NS = 8;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ena_wr = 0, ena_rx = 0, ena_req = 0, tail_wr = 0, tail_rx = 0;
  logic [1:0] ena_idx = 0, tail_idx = 0;
  logic [31:0] rx_ctx_base = 32'd3, tx_ctx_base = 32'd5;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [7:0] mem_req_len;
  logic [2:0] mem_req_tag, mem_cpl_tag = 0;
  logic mem_cpl_valid = 0;
  logic [NQ-1:0] q_stat_rx, q_stat_tx, db_rx, db_tx;

  always #2 clk = ~clk;

  qctx_enable_ctrl #(.NQ(NQ), .AW(AW), .BASEW(32)) uut (
    .clk(clk), .rst(rst), .ena_wr(ena_wr), .ena_rx(ena_rx), .ena_idx(ena_idx),
    .ena_req(ena_req), .tail_wr(tail_wr), .tail_rx(tail_rx), .tail_idx(tail_idx),
    .rx_ctx_base(rx_ctx_base), .tx_ctx_base(tx_ctx_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_write(mem_req_write), .mem_req_tag(mem_req_tag),
    .mem_cpl_valid(mem_cpl_valid), .mem_cpl_tag(mem_cpl_tag),
    .q_stat_rx(q_stat_rx), .q_stat_tx(q_stat_tx), .db_rx(db_rx), .db_tx(db_tx)
  );

  int checks = 0, errors = 0;
  int issued[NS], starts[NS], dbexp[NS], dbgot[NS], ord[32];
  int ord_n = 0;
  longint last_addr[NS];
  int last_len[NS];
  bit outstanding[NS], mreq[NS], mbusy[NS], men[NS];
  bit wr_seen = 0;
  logic [NS-1:0] stat_v;
  assign stat_v = {q_stat_rx, q_stat_tx};

  always @(posedge clk) begin
    for (int k = 0; k < NS; k++)
      if ({db_rx, db_tx}[k]) dbgot[k]++;
    if (mem_req_valid && mem_req_ready) begin
      issued[mem_req_tag]++;
      outstanding[mem_req_tag] = 1'b1;
      last_addr[mem_req_tag] = longint'(mem_req_addr);
      last_len[mem_req_tag] = int'(mem_req_len);
      if (mem_req_write) wr_seen = 1'b1;
      if (ord_n < 32) begin ord[ord_n] = int'(mem_req_tag); ord_n++; end
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic longint exp_addr(int k);
    if (k >= NQ) return longint'(rx_ctx_base) * 512 + 32 * (k % NQ);
    return longint'(tx_ctx_base) * 512 + 128 * (k % NQ);
  endfunction

  function automatic int rr_next(bit [NS-1:0] pend, int last);
    for (int off = 1; off <= NS; off++)
      if (pend[(last + off) % NS]) return (last + off) % NS;
    return -1;
  endfunction

  task automatic tick(input bit ew, input int ek, input bit ev,
                      input bit tw, input int tk, input bit cv, input int ck);
    ena_wr = ew; ena_rx = (ek >= NQ); ena_idx = 2'(ek % NQ); ena_req = ev;
    tail_wr = tw; tail_rx = (tk >= NQ); tail_idx = 2'(tk % NQ);
    mem_cpl_valid = cv; mem_cpl_tag = 3'(ck);
    if (cv) outstanding[ck] = 1'b0;
    for (int k = 0; k < NS; k++) begin
      bit eh, th, chh, rn;
      eh = ew && ek == k; th = tw && tk == k; chh = cv && ck == k;
      rn = eh ? ev : mreq[k];
      if ((th && men[k]) || (chh && mbusy[k] && rn)) dbexp[k]++;
      if (eh && ev && !mbusy[k] && !men[k]) begin mbusy[k] = 1; starts[k]++; end
      else if (chh && mbusy[k]) begin mbusy[k] = 0; men[k] = rn; end
      else if (eh && !ev) men[k] = 0;
      mreq[k] = rn;
    end
    @(negedge clk);
    ena_wr = 0; tail_wr = 0; mem_cpl_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      issued[k] = 0; starts[k] = 0; dbexp[k] = 0; dbgot[k] = 0;
      outstanding[k] = 0; mreq[k] = 0; mbusy[k] = 0; men[k] = 0;
    end
    ord_n = 0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic model_check(input string rq);
    for (int k = 0; k < NS; k++) begin
      chk(stat_v[k] == men[k], {rq, " status"}, stat_v[k], men[k]);
      chk(dbgot[k] == dbexp[k], {rq, " doorbells"}, dbgot[k], dbexp[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk(stat_v == 0 && !mem_req_valid && {db_rx, db_tx} == 0, "R1", stat_v, 0);

    // R2 receive queue 2 (k=6)
    tick(1, 6, 1, 0, 0, 0, 0); idle(3);
    chk(issued[6] == 1, "R2 count", issued[6], 1);
    chk(last_addr[6] == exp_addr(6), "R2 addr", last_addr[6], exp_addr(6));
    chk(last_len[6] == 32, "R2 len", last_len[6], 32);
    chk(!wr_seen, "R2 read", wr_seen, 0);
    chk(stat_v[6] == 0, "R4 not yet", stat_v[6], 0);
    // R3 repeat during fetch, R6 tail while enabling
    tick(1, 6, 1, 1, 6, 0, 0); idle(3);
    chk(issued[6] == 1, "R3 enabling", issued[6], 1);
    chk(dbgot[6] == 0, "R6 gated", dbgot[6], 0);
    // R4 completion
    tick(0, 0, 0, 0, 0, 1, 6);
    chk(stat_v[6] == 1, "R4 status", stat_v[6], 1);
    idle(1);
    chk(dbgot[6] == 1, "R4 doorbell", dbgot[6], 1);
    tick(0, 0, 0, 1, 6, 0, 0); idle(2);
    chk(dbgot[6] == 2, "R6 enabled", dbgot[6], 2);
    tick(1, 6, 1, 0, 0, 0, 0); idle(3);
    chk(issued[6] == 1, "R3 enabled", issued[6], 1);
    // R5 disable
    tick(1, 6, 0, 0, 0, 0, 0);
    chk(stat_v[6] == 0, "R5 status", stat_v[6], 0);
    idle(3);
    chk(issued[6] == 1 && ord_n == 1, "R5 no read", ord_n, 1);
    tick(0, 0, 0, 1, 6, 0, 0); idle(2);
    chk(dbgot[6] == 2, "R6 after disable", dbgot[6], 2);

    // R7 cancel during fetch on transmit queue 1
    tick(1, 1, 1, 0, 0, 0, 0); idle(3);
    chk(last_addr[1] == exp_addr(1), "R2 tx addr", last_addr[1], exp_addr(1));
    chk(last_len[1] == 128, "R2 tx len", last_len[1], 128);
    tick(1, 1, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 1); idle(2);
    chk(stat_v[1] == 0, "R7 status", stat_v[1], 0);
    chk(dbgot[1] == 0, "R7 doorbell", dbgot[1], 0);

    // R9 same-cycle completion and tail
    tick(1, 4, 1, 0, 0, 0, 0); tick(1, 3, 1, 0, 0, 0, 0); idle(3);
    tick(0, 0, 0, 0, 0, 1, 3); idle(1);
    tick(0, 0, 0, 1, 3, 1, 4); idle(2);
    chk(dbgot[4] == 1, "R9 cpl other", dbgot[4], 1);
    chk(dbgot[3] == 2, "R9 tail other", dbgot[3], 2);
    tick(1, 5, 1, 0, 0, 0, 0); idle(3);
    tick(0, 0, 0, 1, 5, 1, 5); idle(2);
    chk(dbgot[5] == 1, "R9 same queue", dbgot[5], 1);
    model_check("R9");

    // R8 rotation with stalled port
    do_reset();
    mem_req_ready = 1'b0;
    tick(1, 5, 1, 0, 0, 0, 0); tick(1, 2, 1, 0, 0, 0, 0);
    tick(1, 7, 1, 0, 0, 0, 0); tick(1, 0, 1, 0, 0, 0, 0); idle(3);
    chk(mem_req_valid && mem_req_tag == 3'd5, "R8 held", mem_req_tag, 5);
    chk(mem_req_addr == 64'(exp_addr(5)), "R8 held addr", mem_req_addr, exp_addr(5));
    mem_req_ready = 1'b1; idle(8);
    begin
      bit [NS-1:0] pend;
      int last, exp;
      pend = 8'b1010_0101; last = -1;
      exp = 5; pend[5] = 0; last = 5;
      chk(ord_n == 4, "R8 count", ord_n, 4);
      chk(ord[0] == exp, "R8 order", ord[0], exp);
      for (int i = 1; i < 4; i++) begin
        exp = rr_next(pend, last); pend[exp] = 0; last = exp;
        chk(ord[i] == exp, "R8 order", ord[i], exp);
      end
    end

    // random phase against the model (R2 R3 R4 R5 R6 R7 R9)
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int ek, tk, ck;
      bit ew, tw, cv;
      mem_req_ready = ($urandom % 4) != 0;
      ew = ($urandom % 3) == 0; ek = $urandom % NS;
      tw = ($urandom % 3) == 0; tk = $urandom % NS;
      ck = $urandom % NS; cv = outstanding[ck] && (($urandom % 2) == 0);
      tick(ew, ek, ($urandom % 4) != 0, tw, tk, cv, ck);
      for (int k = 0; k < NS; k++)
        if (stat_v[k] != men[k]) chk(0, "R4/R5 random status", stat_v[k], men[k]);
    end
    mem_req_ready = 1'b1; idle(20);
    for (int k = 0; k < NS; k++) if (outstanding[k]) tick(0, 0, 0, 0, 0, 1, k);
    idle(3);
    for (int k = 0; k < NS; k++)
      chk(issued[k] == starts[k], "R3 random fetch count", issued[k], starts[k]);
    model_check("R6 random");
    chk(!wr_seen, "R2 never write", wr_seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule